// File: doc/BRIEF.md
# Serial-Programmed Clock Output Enable Controller

This block sits beside a seven-output clock fanout buffer and decides which outputs run. A host programs it over a two-wire serial bus (I2C) using write transfers only. The bus lines are sampled by a faster system clock. The block finds START and STOP conditions, shifts bytes in MSB first, and acknowledges a byte by pulling SDA low through an open-drain enable during the ninth SCL pulse.

A transfer must begin with the full address byte 0xD2, which is a write. Two header bytes follow, a command byte and a count byte. The block acknowledges both and discards their contents. After them come the data bytes, which fill control byte 0, then byte 1, and onward. No sub-address exists, so changing a later byte means resending every earlier one. The block stores up to ten data bytes per transfer. Only bytes 0 and 1 drive outputs.

Each enable bit crosses into the reference clock domain through flops clocked on the falling edge. It then gates that clock with an AND. A stopped output therefore rests low and never emits a shortened pulse.

Top module: `clk_fanout_ctrl`

## Requirements
- R1: After reset all seven enables read 1, SDA is not driven, and every gated output follows the reference clock.
- R2: An address byte of exactly 0xD2 is acknowledged by driving SDA low during the ninth SCL high phase. The drive changes only while SCL is low.
- R3: Any other address byte, including the read address 0xD3, gets no acknowledge. SDA stays undriven until the next START, and the stored enables do not change.
- R4: The command byte and count byte after the address are always acknowledged. Their values never change an enable.
- R5: Data bytes go to control bytes 0, 1, 2 and so on in arrival order. A transfer that ends after byte 0 leaves byte 1 unchanged. Byte 0 bit 2 drives output 0, bit 3 drives output 1, and bit 7 drives output 2.
- R6: Byte 1 bit 2 drives output 3, bit 3 drives output 4, bit 6 drives output 5, and bit 7 drives output 6. A value of 1 enables an output and 0 stops it. All other bits of bytes 0 and 1 have no effect.
- R7: Ten data bytes are acknowledged per transfer. An eleventh is neither acknowledged nor stored. Data bytes 2 to 9 affect no output.
- R8: A repeated START or a STOP returns the block to waiting for an address. The data of the next transfer starts again at control byte 0.
- R9: A control byte takes effect when its acknowledge ends, on the SCL falling edge after the ninth pulse. Before that edge the enables are unchanged.
- R10: A stopped output stays low. A running output equals the reference clock. An enable change is applied only while the reference clock is low.
- R11: A STOP that arrives in the middle of a data byte discards the partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| ref_clk_i | input | 1 | Reference clock to be fanned out |
| en_o | output | 7 | Current enables in the system clock domain, bit i for output i |
| clk_o | output | 7 | Gated reference clock outputs |

## Verification
The hardest case to reach is the acknowledge boundary. Enables must hold through the ninth SCL high phase and change only after the following falling edge. The bench reads the enables in the middle of that acknowledge pulse and again after it ends. Overflow and restart are also hard to reach, because they need long legal transfers. The bench drives an eleven-byte data run and a repeated START placed between data bytes, so the byte counter wraps back to control byte 0. A STOP placed in the middle of a byte checks that partial data is dropped.

// File: rtl/clk_fanout_ctrl_pkg.sv
package clk_fanout_ctrl_pkg;

  localparam int NUM_OUT   = 7;
  localparam int HDR_BYTES = 3;  // address, command, count

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_SKIP
  } phase_e;

  // enable bit positions in control bytes 0 and 1
  function automatic logic [NUM_OUT-1:0] map_enables(input logic [7:0] b0,
                                                     input logic [7:0] b1);
    return {b1[7], b1[6], b1[3], b1[2], b0[7], b0[3], b0[2]};
  endfunction

endpackage

// File: rtl/cfc_sync.sv
module cfc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0,
  parameter bit   ON_FALL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (ON_FALL) begin : g_fall
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end else begin : g_rise
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfc_i2c_wr_rx.sv
module cfc_i2c_wr_rx
  import clk_fanout_ctrl_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR    = 8'hD2,
  parameter int         NUM_DATA    = 10,
  parameter int         SYNC_STAGES = 2,
  localparam int        IDX_W       = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1,
  localparam int        BI_W        = $clog2(NUM_DATA + HDR_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic             wr_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);

  logic scl_s, sda_s, scl_q, sda_q;

  cfc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .ON_FALL(1'b0)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s)
  );
  cfc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .ON_FALL(1'b0)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  logic start_det, stop_det, scl_rise, scl_fall;
  assign start_det = scl_s & scl_q &  sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q &  sda_s;
  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;

  phase_e          phase_q;
  logic [3:0]      bit_cnt_q;
  logic [BI_W-1:0] byte_idx_q;
  logic [7:0]      shreg_q;
  logic            oe_q;

  logic accept, is_data, ack_end;
  assign accept  = (byte_idx_q == '0) ? (shreg_q == DEV_ADDR)
                 : (int'(byte_idx_q) < HDR_BYTES + NUM_DATA);
  assign is_data = int'(byte_idx_q) >= HDR_BYTES;
  assign ack_end = (phase_q == PH_ACK) && scl_fall && !start_det && !stop_det;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      shreg_q    <= '0;
      oe_q       <= 1'b0;
    end else if (start_det) begin
      phase_q    <= PH_RX;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      oe_q       <= 1'b0;
    end else if (stop_det) begin
      phase_q    <= PH_IDLE;
      oe_q       <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_RX: begin
          if (scl_rise && bit_cnt_q != 4'd8) begin
            shreg_q   <= {shreg_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end
          if (scl_fall && bit_cnt_q == 4'd8) begin
            if (accept) begin
              phase_q <= PH_ACK;
              oe_q    <= 1'b1;
            end else begin
              phase_q <= PH_SKIP;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            oe_q       <= 1'b0;
            phase_q    <= PH_RX;
            bit_cnt_q  <= '0;
            byte_idx_q <= byte_idx_q + BI_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  logic [BI_W-1:0] data_idx;
  assign data_idx  = byte_idx_q - BI_W'(HDR_BYTES);

  assign sda_oe_o  = oe_q;
  assign wr_o      = ack_end && is_data;
  assign wr_idx_o  = data_idx[IDX_W-1:0];
  assign wr_data_o = shreg_q;

endmodule

// File: rtl/cfc_ctrl_regs.sv
module cfc_ctrl_regs
  import clk_fanout_ctrl_pkg::*;
#(
  parameter int  NUM_DATA = 10,
  localparam int IDX_W    = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [7:0]         wr_data_i,
  output logic [NUM_OUT-1:0] en_o
);

  logic [7:0] bank_q [NUM_DATA];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_DATA; i++) bank_q[i] <= 8'hFF;
    end else if (wr_i) begin
      for (int i = 0; i < NUM_DATA; i++)
        if (wr_idx_i == IDX_W'(i)) bank_q[i] <= wr_data_i;
    end
  end

  assign en_o = map_enables(bank_q[0], bank_q[1]);

  // bytes 2.. and reserved bits are held but steer nothing
  logic unused_fold;
  always_comb begin
    unused_fold = ^{bank_q[0][6:4], bank_q[0][1:0], bank_q[1][5:4], bank_q[1][1:0]};
    for (int i = 2; i < NUM_DATA; i++) unused_fold = unused_fold ^ (^bank_q[i]);
  end

endmodule

// File: rtl/cfc_clk_gate.sv
module cfc_clk_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);

  logic en_s;

  // falling-edge flops: enable only moves while the clock is low
  cfc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .ON_FALL(1'b1)) u_en_sync (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(en_i), .q_o(en_s)
  );

  assign clk_o = ref_clk_i & en_s;

endmodule

// File: rtl/clk_fanout_ctrl.sv
module clk_fanout_ctrl
  import clk_fanout_ctrl_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR        = 8'hD2,
  parameter int         NUM_DATA        = 10,
  parameter int         BUS_SYNC_STAGES = 2,
  parameter int         OUT_SYNC_STAGES = 2,
  localparam int        IDX_W           = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic               ref_clk_i,
  output logic [NUM_OUT-1:0] en_o,
  output logic [NUM_OUT-1:0] clk_o
);

  logic             wr;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  cfc_i2c_wr_rx #(
    .DEV_ADDR(DEV_ADDR), .NUM_DATA(NUM_DATA), .SYNC_STAGES(BUS_SYNC_STAGES)
  ) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .sda_oe_o(sda_oe_o), .wr_o(wr), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  cfc_ctrl_regs #(.NUM_DATA(NUM_DATA)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .en_o(en_o)
  );

  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
      cfc_clk_gate #(.SYNC_STAGES(OUT_SYNC_STAGES)) u_gate (
        .ref_clk_i(ref_clk_i), .rst_ni(rst_ni), .en_i(en_o[g]), .clk_o(clk_o[g])
      );
    end
  endgenerate

endmodule

// File: rtl/clk_fanout_ctrl_sva.sv
module clk_fanout_ctrl_sva
  import clk_fanout_ctrl_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_i,
  input logic               sda_oe_o,
  input logic               ref_clk_i,
  input logic [NUM_OUT-1:0] en_o,
  input logic [NUM_OUT-1:0] clk_o
);

  a_r2_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  a_r2_ack_not_a_blip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |=> sda_oe_o);

  a_r9_en_moves_at_ack_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o != $past(en_o)) |-> ($past(sda_oe_o) && !sda_oe_o));

  a_r10_gated_low_when_ref_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clk_o) |-> ref_clk_i);

endmodule

bind clk_fanout_ctrl clk_fanout_ctrl_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .ref_clk_i(ref_clk_i), .en_o(en_o), .clk_o(clk_o)
);

// File: tb/clk_fanout_ctrl_bench.sv
`timescale 1ns/1ps
module clk_fanout_ctrl_bench;

  localparam int Q = 30;  // quarter SCL period, ns

  logic       clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_oe;
  logic       sda_bus;
  logic [6:0] en, clk_out;

  int n_chk = 0;
  int n_bad = 0;
  int oe_hits = 0;

  assign sda_bus = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;
  initial begin
    #1;
    forever #20 ref_clk = ~ref_clk;
  end

  always @(posedge clk) if (sda_oe) oe_hits++;

  clk_fanout_ctrl u_clk_fanout_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .ref_clk_i(ref_clk), .en_o(en), .clk_o(clk_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; #Q; scl = 1'b1; #(2*Q); m_sda = 1'b0; #(2*Q); scl = 1'b0; #Q;
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; #Q; scl = 1'b1; #(2*Q); m_sda = 1'b1; #(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      #Q; m_sda = b[i]; #Q; scl = 1'b1; #(2*Q); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output logic [6:0] en_mid);
    send_bits(b, 8);
    #Q; m_sda = 1'b1; #Q; scl = 1'b1; #Q;
    ack = ~sda_bus;
    en_mid = en;
    #Q; scl = 1'b0; #(2*Q);
  endtask

  task automatic write_pair(input logic [7:0] b0, input logic [7:0] b1, output int acks);
    logic a;
    logic [6:0] m;
    acks = 0;
    i2c_start();
    send_byte(8'hD2, a, m); acks += int'(a);
    send_byte(8'h5A, a, m); acks += int'(a);
    send_byte(8'hC3, a, m); acks += int'(a);
    send_byte(b0, a, m);    acks += int'(a);
    send_byte(b1, a, m);    acks += int'(a);
    i2c_stop();
  endtask

  task automatic check_clocks(input string req, input logic [6:0] exp);
    repeat (4) @(posedge ref_clk);
    @(posedge ref_clk); #5;
    chk(req, clk_out, exp);
    @(negedge ref_clk); #5;
    chk(req, clk_out, 7'h00);
  endtask

  // {byte0, byte1, expected enables}
  localparam logic [22:0] VEC [6] = '{
    {8'h00, 8'h00, 7'h00},
    {8'hFF, 8'hFF, 7'h7F},
    {8'h04, 8'h00, 7'h01},
    {8'h88, 8'h44, 7'h2E},
    {8'h73, 8'h33, 7'h00},
    {8'hFF, 8'h80, 7'h47}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int acks;
    logic a;
    logic [6:0] m;

    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 en", en, 7'h7F);
    chk("R1 oe", sda_oe, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_clocks("R1 R10 clocks", 7'h7F);

    // R2 R4 R5 R6 table
    for (int v = 0; v < 6; v++) begin
      write_pair(VEC[v][22:15], VEC[v][14:7], acks);
      chk("R2 R4 acks", acks, 5);
      chk("R5 R6 enables", en, VEC[v][6:0]);
    end

    // R10 mixed pattern 0x47
    check_clocks("R10 gated", 7'h47);

    // R4 R9 R5: byte 0 only, observe mid-ack
    i2c_start();
    send_byte(8'hD2, a, m);
    send_byte(8'h00, a, m); chk("R4 cmd ack", a, 1'b1); chk("R4 cmd no effect", en, 7'h47);
    send_byte(8'hFF, a, m); chk("R4 cnt ack", a, 1'b1); chk("R4 cnt no effect", en, 7'h47);
    send_byte(8'h00, a, m);
    chk("R9 held during ack", m, 7'h47);
    chk("R9 applied after ack", en, 7'h40);
    i2c_stop();
    chk("R5 byte1 kept", en, 7'h40);

    // R3 wrong address and read address
    oe_hits = 0;
    acks = 0;
    i2c_start();
    send_byte(8'hA2, a, m); acks += int'(a);
    send_byte(8'h00, a, m); acks += int'(a);
    send_byte(8'h00, a, m); acks += int'(a);
    send_byte(8'hFF, a, m); acks += int'(a);
    i2c_stop();
    i2c_start();
    send_byte(8'hD3, a, m); acks += int'(a);
    send_byte(8'h00, a, m); acks += int'(a);
    send_byte(8'h00, a, m); acks += int'(a);
    send_byte(8'hFF, a, m); acks += int'(a);
    i2c_stop();
    chk("R3 no acks", acks, 0);
    chk("R3 never drove", oe_hits, 0);
    chk("R3 en unchanged", en, 7'h40);

    // R7 ten data bytes then an eleventh
    acks = 0;
    i2c_start();
    send_byte(8'hD2, a, m); send_byte(8'h00, a, m); send_byte(8'h00, a, m);
    send_byte(8'hFF, a, m); acks += int'(a);
    send_byte(8'hFF, a, m); acks += int'(a);
    for (int k = 0; k < 8; k++) begin
      send_byte(8'h00, a, m); acks += int'(a);
    end
    chk("R7 ten acked", acks, 10);
    send_byte(8'h00, a, m);
    chk("R7 eleventh nak", a, 1'b0);
    i2c_stop();
    chk("R7 upper bytes no effect", en, 7'h7F);

    // R8 repeated start restarts at byte 0
    i2c_start();
    send_byte(8'hD2, a, m); send_byte(8'h00, a, m); send_byte(8'h00, a, m);
    send_byte(8'h00, a, m);
    chk("R8 first b0", en, 7'h78);
    i2c_start();
    send_byte(8'hD2, a, m); chk("R8 addr after restart", a, 1'b1);
    send_byte(8'h00, a, m); send_byte(8'h00, a, m);
    send_byte(8'hFF, a, m); send_byte(8'h00, a, m);
    i2c_stop();
    chk("R8 restart to byte0", en, 7'h07);

    // R11 partial byte dropped
    i2c_start();
    send_byte(8'hD2, a, m); send_byte(8'h00, a, m); send_byte(8'h00, a, m);
    send_bits(8'h00, 4);
    i2c_stop();
    chk("R11 partial dropped", en, 7'h07);

    // R10 stopped outputs low
    check_clocks("R10 stopped low", 7'h07);

    // R1 reset again
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 re-reset en", en, 7'h7F);
    rst_n = 1'b1;
    check_clocks("R1 R10 after reset", 7'h7F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule